// File: doc/BRIEF.md
# Pin Change Interrupt Group Aggregator

This block watches a 27-bit vector of already synchronized general I/O pins, sorted into four groups of unequal size. Whenever a pin that software has enabled in its group's mask changes level, in either direction, the block sets that group's pending flag. Each group drives one interrupt request line toward the interrupt controller. A request is asserted only while the group's flag is pending, the group is enabled and the global interrupt-enable input is high.

Software reaches the block over a small synchronous register bus. Writes take effect on the clock edge; reads are combinational from the current address. There are three kinds of register: one group-enable register, one pending-flag register whose bits clear when written with one, and four per-group pin mask registers. The interrupt controller clears a flag by pulsing that group's acknowledge input when it services the request.

Top module: `pcint_aggregator`

## Requirements
- R1: Group membership is fixed: group 0 holds pins 0 to 7, group 1 holds pins 8 to 14, group 2 holds pins 16 to 23 and group 3 holds pins 24 to 26. Pin 15 belongs to no group, and changes on it set no flag.
- R2: A change of level on a masked-in pin, whether rising or falling, sets the group's pending flag on the first clock edge at which the new level is sampled. Change detection compares each pin with its value at the previous clock edge.
- R3: A change on a pin whose mask bit is zero has no effect on any pending flag.
- R4: The mask register of group g sits at address 4+g. Bit i enables pin (first pin of group g)+i. Bits with no pin behind them read as zero: bit 7 of group 1, and bits 7:3 of group 3. Addresses 2 and 3 read as zero, and writes to them are ignored.
- R5: The group-enable register sits at address 0. Bit g enables group g, and bits 7:4 always read as zero.
- R6: The request grpIrq[g] is high exactly when the pending flag of group g, its enable bit and globalIntEn are all one. A pending flag still sets while its group or the global enable is off.
- R7: The pending-flag register sits at address 1, with bit g as group g's flag. Writing one to a bit clears that flag. Writing zero leaves it unchanged. Bits 7:4 read as zero.
- R8: A pulse on grpAck[g] clears the pending flag of group g at that clock edge.
- R9: If a change sets a flag on the same edge that an acknowledge or a write of one clears it, the flag ends up set.
- R10: After reset, every register reads zero and every request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 27 | Synchronized pin levels |
| globalIntEn | input | 1 | Global interrupt enable |
| grpAck | input | 4 | Per-group acknowledge pulses |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| grpIrq | output | 4 | Per-group interrupt requests |

## Verification
The hardest case to reach from the ports is a flag that is set and cleared on the same edge. It needs a pin toggle that lines up exactly with either an acknowledge pulse or a write of one to the flag register. The stimulus builds both collisions on purpose, and it also checks that pin 15 and masked-off pins leave every flag untouched. A long run of random pin flips, bus writes and acknowledges then collides these events in many more combinations. A behavioural model of flags, masks and enables checks the requests and the read data on every clock.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
  localparam int NUM_GROUPS = 4;
  localparam int PIN_COUNT  = 27;
  localparam int REG_W      = 8;
  localparam int ADDR_W     = 3;

  localparam logic [ADDR_W-1:0] ADDR_ENABLE    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS     = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK_BASE = 3'd4;

  // first pin of each group
  function automatic int grpLo(input int g);
    case (g)
      0:       return 0;
      1:       return 8;
      2:       return 16;
      default: return 24;
    endcase
  endfunction

  // number of pins in each group
  function automatic int grpWidth(input int g);
    case (g)
      0:       return 8;
      1:       return 7;
      2:       return 8;
      default: return 3;
    endcase
  endfunction

  // change vector padded so every group can be sliced REG_W wide
  localparam int PAD_W = grpLo(NUM_GROUPS-1) + REG_W;

  typedef struct packed {
    logic [NUM_GROUPS-1:0] maskWr;
    logic [NUM_GROUPS-1:0] flagClr;
    logic [REG_W-1:0]      wrData;
  } pcintStrobe_t;
endpackage

// File: rtl/pcint_datapath.sv
module pcint_datapath
  import pcint_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [PIN_COUNT-1:0]                 pinIn,
  input  pcintStrobe_t                         strobe,
  output logic [NUM_GROUPS-1:0]                flagState,
  output logic [NUM_GROUPS-1:0][REG_W-1:0]     maskState
);
  logic [PIN_COUNT-1:0]  pinPrev;
  logic [PIN_COUNT-1:0]  pinChange;
  logic [PAD_W-1:0]      changePad;
  logic [NUM_GROUPS-1:0] hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinIn;
  end

  assign pinChange = pinIn ^ pinPrev;
  assign changePad = {{(PAD_W-PIN_COUNT){1'b0}}, pinChange};

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    localparam int LO = grpLo(g);
    localparam int W  = grpWidth(g);
    localparam logic [REG_W-1:0] KEEP = REG_W'((1 << W) - 1);

    logic [REG_W-1:0] maskReg;
    logic             flagReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 maskReg <= '0;
      else if (strobe.maskWr[g]) maskReg <= strobe.wrData & KEEP;
    end

    assign hitVec[g] = |(changePad[LO +: REG_W] & maskReg);

    // a new change outranks any clear arriving on the same edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagReg <= 1'b0;
      else       flagReg <= hitVec[g] | (flagReg & ~strobe.flagClr[g]);
    end

    assign flagState[g] = flagReg;
    assign maskState[g] = maskReg;

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
      hitVec[g] && strobe.flagClr[g] |=> flagReg);
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
      strobe.flagClr[g] && !hitVec[g] |=> !flagReg);
    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rstN)
      !flagReg && !hitVec[g] |=> !flagReg);
  end
endmodule

// File: rtl/pcint_control.sv
module pcint_control
  import pcint_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [REG_W-1:0]      regWrData,
  input  logic [NUM_GROUPS-1:0] grpAck,
  input  logic                  globalIntEn,
  input  logic [NUM_GROUPS-1:0] flagState,
  output pcintStrobe_t          strobe,
  output logic [NUM_GROUPS-1:0] enableState,
  output logic [NUM_GROUPS-1:0] grpIrq
);
  logic                  enableWr;
  logic                  flagWr;
  logic [NUM_GROUPS-1:0] enableReg;

  assign enableWr = regWe && (regAddr == ADDR_ENABLE);
  assign flagWr   = regWe && (regAddr == ADDR_FLAGS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         enableReg <= '0;
    else if (enableWr) enableReg <= regWrData[NUM_GROUPS-1:0];
  end

  always_comb begin
    strobe.wrData  = regWrData;
    strobe.flagClr = grpAck | ({NUM_GROUPS{flagWr}} & regWrData[NUM_GROUPS-1:0]);
    for (int g = 0; g < NUM_GROUPS; g++)
      strobe.maskWr[g] = regWe && (regAddr == ADDR_MASK_BASE + ADDR_W'(g));
  end

  assign enableState = enableReg;
  assign grpIrq      = flagState & enableReg & {NUM_GROUPS{globalIntEn}};

  assert_enable_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    enableWr |=> enableReg == $past(regWrData[NUM_GROUPS-1:0]));
endmodule

// File: rtl/pcint_aggregator.sv
module pcint_aggregator
  import pcint_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PIN_COUNT-1:0]  pinIn,
  input  logic                  globalIntEn,
  input  logic [NUM_GROUPS-1:0] grpAck,
  input  logic                  regWe,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [REG_W-1:0]      regWrData,
  output logic [REG_W-1:0]      regRdData,
  output logic [NUM_GROUPS-1:0] grpIrq
);
  pcintStrobe_t                     strobe;
  logic [NUM_GROUPS-1:0]            flagState;
  logic [NUM_GROUPS-1:0]            enableState;
  logic [NUM_GROUPS-1:0][REG_W-1:0] maskState;

  pcint_control uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWe       (regWe),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .grpAck      (grpAck),
    .globalIntEn (globalIntEn),
    .flagState   (flagState),
    .strobe      (strobe),
    .enableState (enableState),
    .grpIrq      (grpIrq)
  );

  pcint_datapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .strobe    (strobe),
    .flagState (flagState),
    .maskState (maskState)
  );

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_ENABLE)     regRdData = REG_W'(enableState);
    else if (regAddr == ADDR_FLAGS) regRdData = REG_W'(flagState);
    else
      for (int g = 0; g < NUM_GROUPS; g++)
        if (regAddr == ADDR_MASK_BASE + ADDR_W'(g)) regRdData = maskState[g];
  end
endmodule

// File: tb/tb_pcint_aggregator.sv
module tb_pcint_aggregator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [26:0] pinIn = '0;
  logic        globalIntEn = 1'b0;
  logic [3:0]  grpAck = '0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [3:0]  grpIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pcint_aggregator dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .globalIntEn(globalIntEn),
    .grpAck(grpAck), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .grpIrq(grpIrq)
  );

  // reference model state
  int          lo [4] = '{0, 8, 16, 24};
  int          wd [4] = '{8, 7, 8, 3};
  logic [26:0] mPrev;
  logic [7:0]  mMask [4];
  logic [3:0]  mEn, mFlag;
  logic [26:0] pinState = '0;

  task automatic checkEq(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRead(input logic [2:0] a);
    if (a == 3'd0)      return {4'b0, mEn};
    else if (a == 3'd1) return {4'b0, mFlag};
    else if (a >= 3'd4) return mMask[a - 3'd4];
    else                return 8'h00;
  endfunction

  // model update on each edge, comparison shortly after
  always @(posedge clk) begin
    logic [26:0] chg;
    logic [3:0]  nf;
    logic        hit, clr;
    if (!rstN) begin
      mPrev = '0; mEn = '0; mFlag = '0;
      for (int g = 0; g < 4; g++) mMask[g] = '0;
    end else begin
      chg = pinIn ^ mPrev;
      for (int g = 0; g < 4; g++) begin
        hit = 1'b0;
        for (int i = 0; i < wd[g]; i++)
          if (mMask[g][i] && chg[lo[g] + i]) hit = 1'b1;
        clr = grpAck[g] || (regWe && regAddr == 3'd1 && regWrData[g]);
        nf[g] = hit || (mFlag[g] && !clr);
      end
      if (regWe) begin
        if (regAddr == 3'd0) mEn = regWrData[3:0];
        if (regAddr >= 3'd4)
          mMask[regAddr - 3'd4] = regWrData & 8'((1 << wd[regAddr - 3'd4]) - 1);
      end
      mFlag = nf;
      mPrev = pinIn;
    end
    #5;
    if (!finished) begin
      checkEq(grpIrq, mEn & mFlag & {4{globalIntEn}}, "R6 model irq");
      checkEq(regRdData, modelRead(regAddr),
              regAddr == 3'd0 ? "R5 model read" :
              regAddr == 3'd1 ? "R7 model read" : "R4 model read");
    end
  end

  task automatic drive(input logic [26:0] p, input logic w, input logic [2:0] a,
                       input logic [7:0] d, input logic [3:0] k);
    @(negedge clk);
    pinIn = p; regWe = w; regAddr = a; regWrData = d; grpAck = k;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    drive(pinState, 1'b1, a, d, 4'h0);
  endtask

  task automatic toggle(input int pin);
    pinState[pin] = ~pinState[pin];
    drive(pinState, 1'b0, 3'd0, 8'h00, 4'h0);
  endtask

  task automatic readExp(input logic [2:0] a, input logic [7:0] exp, input string tag);
    drive(pinState, 1'b0, a, 8'h00, 4'h0);
    @(posedge clk);
    #6;
    checkEq(regRdData, exp, tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    readExp(3'd0, 8'h00, "R10 enable after reset");
    readExp(3'd1, 8'h00, "R10 flags after reset");
    readExp(3'd4, 8'h00, "R10 mask after reset");
    checkEq(grpIrq, 4'h0, "R10 irq after reset");

    // R4 mask layout
    for (int g = 0; g < 4; g++) wr(3'(4 + g), 8'hFF);
    readExp(3'd4, 8'hFF, "R4 mask0");
    readExp(3'd5, 8'h7F, "R4 mask1 top bit");
    readExp(3'd6, 8'hFF, "R4 mask2");
    readExp(3'd7, 8'h07, "R4 mask3 top bits");
    wr(3'd2, 8'hFF);
    readExp(3'd2, 8'h00, "R4 unused address");

    // R5 enable register
    wr(3'd0, 8'hFF);
    readExp(3'd0, 8'h0F, "R5 reserved bits");
    globalIntEn = 1'b1;

    // R2 rising and falling, R7 and R8 clears
    toggle(3);
    readExp(3'd1, 8'h01, "R2 rising edge");
    checkEq(grpIrq, 4'h1, "R6 irq raised");
    wr(3'd1, 8'h01);
    readExp(3'd1, 8'h00, "R7 write one clears");
    toggle(3);
    readExp(3'd1, 8'h01, "R2 falling edge");
    drive(pinState, 1'b0, 3'd0, 8'h00, 4'h1);
    readExp(3'd1, 8'h00, "R8 acknowledge clears");

    // R1 group membership
    toggle(15);
    readExp(3'd1, 8'h00, "R1 pin 15 unmapped");
    toggle(8);
    readExp(3'd1, 8'h02, "R1 pin 8 group1");
    toggle(16);
    readExp(3'd1, 8'h06, "R1 pin 16 group2");
    toggle(26);
    readExp(3'd1, 8'h0E, "R1 pin 26 group3");
    wr(3'd1, 8'h0F);
    readExp(3'd1, 8'h00, "R7 clear all");
    toggle(8);
    wr(3'd1, 8'h00);
    readExp(3'd1, 8'h02, "R7 write zero no effect");
    wr(3'd1, 8'h02);

    // R3 masked-off pin
    wr(3'd4, 8'h02);
    toggle(2);
    readExp(3'd1, 8'h00, "R3 masked pin ignored");
    toggle(1);
    readExp(3'd1, 8'h01, "R3 enabled pin sets");

    // R9 set and clear on the same edge
    pinState[1] = ~pinState[1];
    drive(pinState, 1'b0, 3'd0, 8'h00, 4'h1);
    readExp(3'd1, 8'h01, "R9 change beats acknowledge");
    pinState[1] = ~pinState[1];
    drive(pinState, 1'b1, 3'd1, 8'h01, 4'h0);
    readExp(3'd1, 8'h01, "R9 change beats write clear");

    // R6 gating
    globalIntEn = 1'b0;
    readExp(3'd1, 8'h01, "R6 flag kept while gated");
    checkEq(grpIrq, 4'h0, "R6 global enable off");
    globalIntEn = 1'b1;
    wr(3'd0, 8'h0E);
    readExp(3'd1, 8'h01, "R6 flag kept group disabled");
    checkEq(grpIrq, 4'h0, "R6 group disabled");
    wr(3'd0, 8'h0F);
    readExp(3'd0, 8'h0F, "R5 enable rewritten");
    checkEq(grpIrq, 4'h1, "R6 irq restored");

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] a;
      pinState = pinState ^ (27'($urandom) & 27'($urandom) & 27'($urandom));
      a = 3'($urandom);
      if ($urandom % 16 == 0) globalIntEn = ~globalIntEn;
      drive(pinState, ($urandom % 4) == 0, a, 8'($urandom),
            4'($urandom) & 4'($urandom));
    end
    drive(pinState, 1'b0, 3'd0, 8'h00, 4'h0);
    @(posedge clk);
    #8;
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule